// File: doc/BRIEF.md
# Bus-Matching Width Converter with Selectable Sub-Word Order

This block sits between a 36-bit word store and two external data ports. It lets the write port and the read port run narrower than the stored word. On the write side it gathers 18-bit or 9-bit input words into one full entry. On the read side it hands out one full entry as a run of 18-bit or 9-bit output words. Only one side can be narrow at a time, and the port widths come from a fixed table that three mode pins select.

A fourth pin decides which end of the full word goes first. It can be the most significant end (big-endian) or the least significant end (little-endian). All four pins are sampled while the synchronous master reset is held low, and they are then held until the next reset. The store is modelled as a head-of-queue word with an availability flag and a pop strobe on the read side, and as a write strobe with data on the write side. One clock drives everything.

Top module: `bm_width_conv`

## Requirements
- R1: With `cfg_bus_match` low, both ports are 36 bits wide and `cfg_in_narrow`/`cfg_out_quarter` have no effect. Each accepted write is committed unchanged one cycle later, and each served read returns the whole head entry.
- R2: With `cfg_bus_match` high, `cfg_in_narrow` low and `cfg_out_quarter` low, writes are 36 bits and each entry is read as two 18-bit words, taken from lanes bits 17:0 and 35:18.
- R3: With `cfg_bus_match` high, `cfg_in_narrow` low and `cfg_out_quarter` high, writes are 36 bits and each entry is read as four 9-bit words, taken from lanes bits 8:0, 17:9, 26:18 and 35:27.
- R4: With `cfg_bus_match` high and `cfg_in_narrow` high, reads are 36 bits wide. Writes are 18 bits wide (`cfg_out_quarter` low) or 9 bits wide (high), placed in the same lanes as in R2/R3. Bits of `wr_data` above the narrow width are ignored.
- R5: With `cfg_big_endian` high, the lane holding the most significant bits is transferred first and the least significant lane last, on both the narrow write and the narrow read side.
- R6: With `cfg_big_endian` low, the least significant lane is transferred first and the most significant lane last.
- R7: The four mode pins are captured only while `rst_n` is low. Changing them after reset is released has no effect on widths or order.
- R8: With a narrow read port, `mem_rd_en` pulses only in the cycle that serves the last sub-word of the head entry. Reading fewer sub-words than an entry holds leaves the store unpopped.
- R9: With a narrow write port, `mem_wr_en` pulses only after all sub-words of an entry have been accepted. A partly gathered entry is dropped by master reset and never committed.
- R10: Outputs are registered. `rd_valid` rises in the cycle after a request is made while `mem_rd_avail` is high, and it stays low for a request made while `mem_rd_avail` is low. During reset `rd_valid` and `mem_wr_en` are low.
- R11: In narrow read modes, `rd_data` carries the sub-word in its low bits, and all bits above the sub-word width are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Synchronous master reset, active low; mode pins sampled while low |
| cfg_bus_match | input | 1 | Enables narrow-port modes |
| cfg_in_narrow | input | 1 | Selects the narrow side: high = write side, low = read side |
| cfg_out_quarter | input | 1 | Narrow width: high = 9 bits, low = 18 bits |
| cfg_big_endian | input | 1 | Sub-word order: high = most significant first |
| wr_valid | input | 1 | Write word present |
| wr_data | input | 36 | Write word; narrow modes use the low bits |
| mem_wr_en | output | 1 | Commit strobe to the store |
| mem_wr_data | output | 36 | Full entry to commit |
| rd_req | input | 1 | Read request for one port-width word |
| rd_valid | output | 1 | Read word present on rd_data |
| rd_data | output | 36 | Read word, zero-filled above the port width |
| mem_rd_avail | input | 1 | Store has a head entry |
| mem_rd_data | input | 36 | Head entry of the store |
| mem_rd_en | output | 1 | Pop strobe for the head entry |

## Verification
The embedded assertions check, on every cycle, properties that need no reference data. Mode pins stay stable after reset. Commits only follow an accepted write. The lane index stays within the current width. A pop returns the index to the first lane. A read word only follows a served request. Narrow read words are zero-filled above their width. Whether the right lane comes out or goes in, in the right order for each width and endian setting, can only be shown by the bench scenarios. These scenarios compare against entries built independently. The same holds for the checks that changing the pins after reset has no effect, and that a partial entry is dropped by reset.

// File: rtl/bm_pkg.sv
package bm_pkg;

    typedef enum logic [1:0] {
        PW_FULL    = 2'd0,
        PW_HALF    = 2'd1,
        PW_QUARTER = 2'd2
    } port_w_e;

    typedef struct packed {
        logic bus_match;
        logic in_narrow;
        logic out_quarter;
        logic big_end;
    } bm_cfg_t;

    function automatic port_w_e wr_port_w(bm_cfg_t c);
        if (!c.bus_match || !c.in_narrow) return PW_FULL;
        return c.out_quarter ? PW_QUARTER : PW_HALF;
    endfunction

    function automatic port_w_e rd_port_w(bm_cfg_t c);
        if (!c.bus_match || c.in_narrow) return PW_FULL;
        return c.out_quarter ? PW_QUARTER : PW_HALF;
    endfunction

    function automatic logic [1:0] last_lane(port_w_e w);
        case (w)
            PW_HALF:    return 2'd1;
            PW_QUARTER: return 2'd3;
            default:    return 2'd0;
        endcase
    endfunction

    // Physical lane visited at step k of an entry.
    function automatic logic [1:0] lane_pos(logic [1:0] k, port_w_e w, logic big);
        return big ? (last_lane(w) - k) : k;
    endfunction

endpackage

// File: rtl/bm_mode_latch.sv
module bm_mode_latch
    import bm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  bm_cfg_t pins,
    output bm_cfg_t cfg
);

    bm_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = rst_n ? cfg_q : pins;
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R7: configuration frozen once reset is released
    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q));

endmodule

// File: rtl/bm_pack.sv
module bm_pack
    import bm_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_w_e           port_w,
    input  logic              big_end,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              mem_wr_en,
    output logic [WORD_W-1:0] mem_wr_data
);

    localparam int HALF_W  = WORD_W / 2;
    localparam int QUART_W = WORD_W / 4;

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [1:0]        idx;
        logic              commit;
        logic [WORD_W-1:0] word;
    } pack_st_t;

    pack_st_t st_d, st_q;
    logic [1:0]        lane;
    logic [WORD_W-1:0] merged;

    always_comb begin
        st_d        = st_q;
        st_d.commit = 1'b0;
        lane        = lane_pos(st_q.idx, port_w, big_end);
        merged      = st_q.acc;
        case (port_w)
            PW_HALF:    merged[int'(lane) * HALF_W +: HALF_W]   = wr_data[HALF_W-1:0];
            PW_QUARTER: merged[int'(lane) * QUART_W +: QUART_W] = wr_data[QUART_W-1:0];
            default:    merged = wr_data;
        endcase
        if (wr_valid) begin
            if (st_q.idx == last_lane(port_w)) begin
                st_d.commit = 1'b1;
                st_d.word   = merged;
                st_d.acc    = '0;
                st_d.idx    = 2'd0;
            end else begin
                st_d.acc = merged;
                st_d.idx = st_q.idx + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_wr_en   = st_q.commit;
    assign mem_wr_data = st_q.word;

    // R9: a commit is always caused by an accepted sub-word
    assert_commit_after_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(wr_valid));

    // R9: gather index never passes the last lane of the mode
    assert_idx_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= last_lane(port_w));

    // R1: full-width writes pass straight through one cycle later
    assert_full_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && port_w == PW_FULL) |-> (mem_wr_en == $past(wr_valid)));

endmodule

// File: rtl/bm_unpack.sv
module bm_unpack
    import bm_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_w_e           port_w,
    input  logic              big_end,
    input  logic              rd_req,
    input  logic              mem_rd_avail,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              mem_rd_en,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);

    localparam int HALF_W  = WORD_W / 2;
    localparam int QUART_W = WORD_W / 4;

    typedef struct packed {
        logic [1:0]        idx;
        logic              valid;
        logic [WORD_W-1:0] data;
    } unpack_st_t;

    unpack_st_t st_d, st_q;
    logic [WORD_W-1:0] quart_ext [4];
    logic [WORD_W-1:0] half_ext  [2];
    logic [1:0]        lane;
    logic              take;
    logic [WORD_W-1:0] sel;

    for (genvar g = 0; g < 4; g++) begin : g_quart
        assign quart_ext[g] = {{(WORD_W-QUART_W){1'b0}}, mem_rd_data[g*QUART_W +: QUART_W]};
    end
    for (genvar g = 0; g < 2; g++) begin : g_half
        assign half_ext[g] = {{(WORD_W-HALF_W){1'b0}}, mem_rd_data[g*HALF_W +: HALF_W]};
    end

    always_comb begin
        st_d       = st_q;
        take       = rd_req && mem_rd_avail;
        lane       = lane_pos(st_q.idx, port_w, big_end);
        case (port_w)
            PW_HALF:    sel = half_ext[lane[0]];
            PW_QUARTER: sel = quart_ext[lane];
            default:    sel = mem_rd_data;
        endcase
        st_d.valid = take;
        mem_rd_en  = 1'b0;
        if (take) begin
            st_d.data = sel;
            if (st_q.idx == last_lane(port_w)) begin
                st_d.idx  = 2'd0;
                mem_rd_en = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.valid;
    assign rd_data  = st_q.data;

    // R8: a pop always restarts the walk at the first lane
    assert_pop_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (st_q.idx == 2'd0));

    // R10: a read word only follows a request made while data was available
    assert_valid_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req && mem_rd_avail));

    // R11: quarter-width words are zero above their lane width
    assert_zero_quarter_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && port_w == PW_QUARTER) |-> (rd_data[WORD_W-1:QUART_W] == '0));

    // R11: half-width words are zero above their lane width
    assert_zero_half_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && port_w == PW_HALF) |-> (rd_data[WORD_W-1:HALF_W] == '0));

endmodule

// File: rtl/bm_width_conv.sv
module bm_width_conv
    import bm_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bus_match,
    input  logic              cfg_in_narrow,
    input  logic              cfg_out_quarter,
    input  logic              cfg_big_endian,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              mem_wr_en,
    output logic [WORD_W-1:0] mem_wr_data,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    input  logic              mem_rd_avail,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              mem_rd_en
);

    bm_cfg_t pins;
    bm_cfg_t cfg;
    port_w_e wr_w;
    port_w_e rd_w;

    assign pins = '{bus_match: cfg_bus_match, in_narrow: cfg_in_narrow,
                    out_quarter: cfg_out_quarter, big_end: cfg_big_endian};

    bm_mode_latch u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (pins),
        .cfg   (cfg)
    );

    assign wr_w = wr_port_w(cfg);
    assign rd_w = rd_port_w(cfg);

    bm_pack #(.WORD_W(WORD_W)) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_w      (wr_w),
        .big_end     (cfg.big_end),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_data (mem_wr_data)
    );

    bm_unpack #(.WORD_W(WORD_W)) u_unpack (
        .clk          (clk),
        .rst_n        (rst_n),
        .port_w       (rd_w),
        .big_end      (cfg.big_end),
        .rd_req       (rd_req),
        .mem_rd_avail (mem_rd_avail),
        .mem_rd_data  (mem_rd_data),
        .mem_rd_en    (mem_rd_en),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data)
    );

endmodule

// File: tb/bm_width_conv_bench.sv
`timescale 1ns/1ps
module bm_width_conv_bench;

    localparam int W = 36;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         p_bm = 1'b0, p_iw = 1'b0, p_ow = 1'b0, p_be = 1'b0;
    logic         wr_valid = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         mem_wr_en;
    logic [W-1:0] mem_wr_data;
    logic         rd_req = 1'b0;
    logic         rd_valid;
    logic [W-1:0] rd_data;
    logic         mem_rd_avail;
    logic [W-1:0] mem_rd_data;
    logic         mem_rd_en;

    int checks = 0;
    int fails  = 0;
    int writes_seen = 0;
    bit done = 1'b0;
    string tag = "R10";

    logic [W-1:0] exp_wr[$];
    logic [W-1:0] exp_rd[$];

    logic [W-1:0] bmem [16];
    int bcnt = 0;
    int bptr;

    assign mem_rd_avail = (bptr < bcnt);
    assign mem_rd_data  = bmem[bptr[3:0]];

    always @(posedge clk) begin
        if (!rst_n)         bptr <= 0;
        else if (mem_rd_en) bptr <= bptr + 1;
    end

    bm_width_conv u_bm_width_conv (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_bus_match   (p_bm),
        .cfg_in_narrow   (p_iw),
        .cfg_out_quarter (p_ow),
        .cfg_big_endian  (p_be),
        .wr_valid        (wr_valid),
        .wr_data         (wr_data),
        .mem_wr_en       (mem_wr_en),
        .mem_wr_data     (mem_wr_data),
        .rd_req          (rd_req),
        .rd_valid        (rd_valid),
        .rd_data         (rd_data),
        .mem_rd_avail    (mem_rd_avail),
        .mem_rd_data     (mem_rd_data),
        .mem_rd_en       (mem_rd_en)
    );

    function automatic logic [W-1:0] sub_of(logic [W-1:0] w, int k, int n, bit big);
        int lane = big ? (n - 1 - k) : k;
        int sw   = W / n;
        logic [W-1:0] r = '0;
        for (int b = 0; b < sw; b++) r[b] = w[lane*sw + b];
        return r;
    endfunction

    function automatic logic [W-1:0] rand_word();
        return {$urandom, $urandom};
    endfunction

    task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp, string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Store-side write monitor
    always @(negedge clk) begin
        if (rst_n && !done && mem_wr_en) begin
            logic [W-1:0] e;
            writes_seen++;
            if (exp_wr.size() == 0) begin
                check(1'b0, tag, mem_wr_data, '0, "unexpected commit");
            end else begin
                e = exp_wr.pop_front();
                check(mem_wr_data === e, tag, mem_wr_data, e, "committed entry");
            end
        end
    end

    // Read-port monitor
    always @(negedge clk) begin
        if (rst_n && !done && rd_valid) begin
            logic [W-1:0] e;
            if (exp_rd.size() == 0) begin
                check(1'b0, {tag, ",R10"}, rd_data, '0, "unexpected read word");
            end else begin
                e = exp_rd.pop_front();
                check(rd_data === e, {tag, ",R11"}, rd_data, e, "read word");
            end
        end
    end

    task automatic do_reset(bit bm, bit iw, bit ow, bit be);
        @(negedge clk);
        rst_n = 1'b0; wr_valid = 1'b0; rd_req = 1'b0;
        p_bm = bm; p_iw = iw; p_ow = ow; p_be = be;
        repeat (3) @(negedge clk);
        check(mem_wr_en == 1'b0, "R10", {35'd0, mem_wr_en}, '0, "mem_wr_en in reset");
        check(rd_valid == 1'b0, "R10", {35'd0, rd_valid}, '0, "rd_valid in reset");
        exp_wr.delete();
        exp_rd.delete();
        bcnt = 0;
        rst_n = 1'b1;
        // R7: scramble pins after release; latched mode must hold
        p_bm = 1'($urandom); p_iw = 1'($urandom); p_ow = 1'($urandom); p_be = 1'($urandom);
    endtask

    task automatic wr_beat(logic [W-1:0] d);
        if ($urandom_range(0, 2) == 0) begin
            wr_valid = 1'b0;
            @(negedge clk);
        end
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    function automatic logic [W-1:0] narrow_beat(logic [W-1:0] e, int k, int n, bit be);
        int sw = W / n;
        logic [W-1:0] mask = {W{1'b1}} >> (W - sw);
        return (rand_word() & ~mask) | sub_of(e, k, n, be);
    endfunction

    task automatic run_mode(bit bm, bit iw, bit ow, bit be, string mtag);
        int wl = (bm && iw) ? (ow ? 4 : 2) : 1;
        int rl = (bm && !iw) ? (ow ? 4 : 2) : 1;
        int w0;
        int p0;
        logic [W-1:0] e;

        // R9: partial entry then reset must not commit
        do_reset(bm, iw, ow, be);
        tag = {mtag, be ? ",R5" : ",R6", ",R7"};
        e = rand_word();
        w0 = writes_seen;
        for (int k = 0; k < wl - 1; k++) wr_beat(narrow_beat(e, k, wl, be));
        repeat (3) @(negedge clk);
        check(writes_seen == w0, "R9", W'(writes_seen), W'(w0), "commits after partial entry");

        do_reset(bm, iw, ow, be);
        tag = {mtag, be ? ",R5" : ",R6", ",R7,R9"};

        // Write path
        for (int i = 0; i < 6; i++) begin
            e = rand_word();
            exp_wr.push_back(e);
            for (int k = 0; k < wl; k++) wr_beat(narrow_beat(e, k, wl, be));
        end
        repeat (3) @(negedge clk);
        check(exp_wr.size() == 0, {mtag, ",R9"}, W'(exp_wr.size()), '0, "entries left uncommitted");

        // Read path, random request pattern
        tag = {mtag, be ? ",R5" : ",R6", ",R7"};
        for (int i = 0; i < 6; i++) begin
            e = rand_word();
            bmem[bcnt] = e;
            bcnt++;
            for (int k = 0; k < rl; k++) exp_rd.push_back(sub_of(e, k, rl, be));
        end
        for (int c = 0; c < 600 && exp_rd.size() > 0; c++) begin
            rd_req = ($urandom_range(0, 3) != 0);
            @(negedge clk);
        end
        rd_req = 1'b1;                  // R10: requests against an empty store
        repeat (4) @(negedge clk);
        rd_req = 1'b0;
        @(negedge clk);
        check(exp_rd.size() == 0, {mtag, ",R10"}, W'(exp_rd.size()), '0, "read words missing");
        check(bptr == bcnt, "R8", W'(bptr), W'(bcnt), "pops after full entries");

        // R8 / R10: step through one entry directed
        e = rand_word();
        bmem[bcnt] = e;
        bcnt++;
        for (int k = 0; k < rl; k++) exp_rd.push_back(sub_of(e, k, rl, be));
        p0 = bptr;
        for (int k = 0; k < rl - 1; k++) begin
            rd_req = 1'b1;
            @(negedge clk);
            rd_req = 1'b0;
            check(bptr == p0, "R8", W'(bptr), W'(p0), "no pop before last sub-word");
            check(rd_valid == 1'b1, "R10", {35'd0, rd_valid}, W'(1), "rd_valid after request");
        end
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check(rd_valid == 1'b1, "R10", {35'd0, rd_valid}, W'(1), "rd_valid after last request");
        check(bptr == p0 + 1, "R8", W'(bptr), W'(p0 + 1), "pop on last sub-word");
        @(negedge clk);
        check(rd_valid == 1'b0, "R10", {35'd0, rd_valid}, '0, "rd_valid drops when idle");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int be = 0; be < 2; be++) begin
            run_mode(1'b0, 1'($urandom), 1'($urandom), 1'(be), "R1");
            run_mode(1'b1, 1'b0, 1'b0, 1'(be), "R2");
            run_mode(1'b1, 1'b0, 1'b1, 1'(be), "R3");
            run_mode(1'b1, 1'b1, 1'b0, 1'(be), "R4");
            run_mode(1'b1, 1'b1, 1'b1, 1'(be), "R4");
        end
        repeat (2) @(negedge clk);
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog: actual hung expected completion");
        finish_up();
    end

endmodule